// File: doc/BRIEF.md
# Crossbar Master Port Access Gate

This block sits on one master port of a crossbar interconnect. Each cycle it decides whether the master's current access goes straight through to its decoded slave port or is held off with wait states. It works from three kinds of per-slave signals: grant, parked-on-this-master and access completion. From these it produces a one-hot request vector for the slave arbiters, a pass-through enable for the data path, and a ready signal back to the master. Address decoding and the data path are outside the block.

The master side follows valid/ready rules. The master raises `m_valid` with a target index `m_tgt` (which must be below `N_SLV`) and attributes `m_attr`. The access is transferred in the cycle where `m_valid` and `m_ready` are both high. If the access cannot pass at once, the gate captures it in the cycle it is first presented. From then on the captured index and attributes drive the slave side until ready rises, and later changes on `m_tgt` and `m_attr` are ignored. The master sees no ownership signal; the only visible sign of not owning a port is a low `m_ready`.

An accepted access stays outstanding on its slave port until that port's `s_done` is seen at a clock edge. No request is raised toward another slave port until then, whatever priority the master holds on the new port. This keeps two masters that wait on each other's ports from locking the crossbar.

Top module: `xbar_mport_gate`

## Requirements
- R1: After reset, with no access presented, `s_req` is all zero and `m_ready` and `pass_en` are low.
- R2: An access to slave k, with `s_grant[k]` or `s_park[k]` high and no outstanding access to another slave, gets `m_ready` and `pass_en` high in the same cycle it is presented, with `s_req` equal to 1 shifted left by k.
- R3: An access to a slave that is neither granted nor parked on this master keeps `m_ready` low and `s_req` on that slave. `m_ready` rises in the first cycle where grant or park for that slave is high.
- R4: While an accepted access to slave a is outstanding, an access to slave b≠a keeps `m_ready` low and `s_req` on a. The outstanding state ends at the clock edge where `s_done[a]` is high, and the request to b appears from the next cycle.
- R5: At most one bit of `s_req` is high in any cycle.
- R6: Once an access is stalled, `s_attr` and the requested slave keep the values captured in the first stalled cycle until `m_ready` rises, whatever the master drives meanwhile. Before capture, `s_attr` follows `m_attr`.
- R7: With no access presented and none outstanding, `s_req` is zero. An outstanding access holds its request until its completion edge, and the request drops in the next cycle if nothing is pending.
- R8: A new access to the same slave as the outstanding one passes as soon as that slave is granted or parked, without waiting for completion.
- R9: `s_done` for a slave other than the outstanding one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Master access valid |
| m_tgt | input | TGT_W | Decoded target slave index |
| m_attr | input | ATTR_W | Access attributes |
| m_ready | output | 1 | Access accepted; low inserts a wait state |
| s_grant | input | N_SLV | Per-slave grant to this master |
| s_park | input | N_SLV | Per-slave parked-on-this-master indication |
| s_done | input | N_SLV | Per-slave access completion |
| s_req | output | N_SLV | One-hot request to the slave arbiters |
| s_attr | output | ATTR_W | Attributes presented toward the slave |
| pass_en | output | 1 | Pass-through enable for the data path |

## Verification
A stuck outstanding flag shows up within one cycle of the next access to a different slave: `s_req` stays on the old port and `m_ready` stays low long after that port's completion. A capture register that fails to load or hold shows up in the first wait cycle after the master changes its index or attributes, through `s_attr` or the position of the `s_req` bit. A fault in the ownership decision shows up in the very cycle a grant or park arrives, as a missing or extra `m_ready`. The bench compares every output every cycle, so each of these is reported within a cycle or two of the faulty state.

// File: rtl/xbg_pkg.sv
package xbg_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_PASS = 2'd1,
    ACT_WAIT = 2'd2,
    ACT_HOLD = 2'd3
  } gate_act_e;
endpackage

// File: rtl/xbg_capture.sv
module xbg_capture #(
  parameter int TGT_W  = 2,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [TGT_W-1:0]  in_tgt,
  input  logic [ATTR_W-1:0] in_attr,
  output logic              held,
  output logic [TGT_W-1:0]  held_tgt,
  output logic [ATTR_W-1:0] held_attr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_tgt  <= '0;
      held_attr <= '0;
    end else if (clear) begin
      held <= 1'b0;
    end else if (load && !held) begin
      held      <= 1'b1;
      held_tgt  <= in_tgt;
      held_attr <= in_attr;
    end
  end
endmodule

// File: rtl/xbg_track.sv
module xbg_track #(
  parameter int N_SLV = 4,
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [TGT_W-1:0] acc_tgt,
  input  logic [N_SLV-1:0] s_done,
  output logic             busy,
  output logic [TGT_W-1:0] busy_tgt
);
  logic done_hit;

  always_comb begin
    done_hit = 1'b0;
    for (int k = 0; k < N_SLV; k++) begin
      if (busy_tgt == TGT_W'(k) && s_done[k]) done_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_tgt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      busy_tgt <= acc_tgt;
    end else if (busy && done_hit) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/xbg_decide.sv
module xbg_decide
  import xbg_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int TGT_W = 2
) (
  input  logic             acc_vld,
  input  logic [TGT_W-1:0] acc_tgt,
  input  logic             busy,
  input  logic [TGT_W-1:0] busy_tgt,
  input  logic [N_SLV-1:0] s_grant,
  input  logic [N_SLV-1:0] s_park,
  output logic [N_SLV-1:0] req,
  output logic             go,
  output gate_act_e        act
);
  logic             blocked;
  logic             owned;
  logic [N_SLV-1:0] own_vec;
  logic [N_SLV-1:0] sel_acc;
  logic [N_SLV-1:0] sel_busy;

  for (genvar k = 0; k < N_SLV; k++) begin : g_slv
    assign own_vec[k]  = s_grant[k] | s_park[k];
    assign sel_acc[k]  = (acc_tgt == TGT_W'(k));
    assign sel_busy[k] = (busy_tgt == TGT_W'(k));
  end

  assign blocked = busy && (busy_tgt != acc_tgt);
  assign owned   = |(own_vec & sel_acc);

  always_comb begin
    req = '0;
    act = ACT_IDLE;
    if (acc_vld && !blocked) begin
      req = sel_acc;
      act = owned ? ACT_PASS : ACT_WAIT;
    end else if (busy) begin
      req = sel_busy;
      act = ACT_HOLD;
    end
  end

  assign go = (act == ACT_PASS);
endmodule

// File: rtl/xbar_mport_gate.sv
module xbar_mport_gate
  import xbg_pkg::*;
#(
  parameter int N_SLV  = 4,
  parameter int ATTR_W = 8,
  localparam int TGT_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  input  logic [TGT_W-1:0]  m_tgt,
  input  logic [ATTR_W-1:0] m_attr,
  output logic              m_ready,
  input  logic [N_SLV-1:0]  s_grant,
  input  logic [N_SLV-1:0]  s_park,
  input  logic [N_SLV-1:0]  s_done,
  output logic [N_SLV-1:0]  s_req,
  output logic [ATTR_W-1:0] s_attr,
  output logic              pass_en
);
  logic              held;
  logic [TGT_W-1:0]  held_tgt;
  logic [ATTR_W-1:0] held_attr;
  logic              busy;
  logic [TGT_W-1:0]  busy_tgt;
  logic              acc_vld;
  logic [TGT_W-1:0]  acc_tgt;
  logic              go;
  gate_act_e         act;

  assign acc_vld = held | m_valid;
  assign acc_tgt = held ? held_tgt : m_tgt;
  assign s_attr  = held ? held_attr : m_attr;

  xbg_capture #(.TGT_W(TGT_W), .ATTR_W(ATTR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (m_valid && !go),
    .clear     (go),
    .in_tgt    (m_tgt),
    .in_attr   (m_attr),
    .held      (held),
    .held_tgt  (held_tgt),
    .held_attr (held_attr)
  );

  xbg_track #(.N_SLV(N_SLV), .TGT_W(TGT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (go),
    .acc_tgt  (acc_tgt),
    .s_done   (s_done),
    .busy     (busy),
    .busy_tgt (busy_tgt)
  );

  xbg_decide #(.N_SLV(N_SLV), .TGT_W(TGT_W)) u_dec (
    .acc_vld  (acc_vld),
    .acc_tgt  (acc_tgt),
    .busy     (busy),
    .busy_tgt (busy_tgt),
    .s_grant  (s_grant),
    .s_park   (s_park),
    .req      (s_req),
    .go       (go),
    .act      (act)
  );

  assign m_ready = go;
  assign pass_en = go && (act == ACT_PASS);
endmodule

// File: rtl/xbg_checker.sv
module xbg_checker #(
  parameter int N_SLV  = 4,
  parameter int ATTR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [N_SLV-1:0]  s_grant,
  input logic [N_SLV-1:0]  s_park,
  input logic [N_SLV-1:0]  s_done,
  input logic [N_SLV-1:0]  s_req,
  input logic [ATTR_W-1:0] s_attr
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_req)); // R5

  AST_READY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |-> (|(s_req & (s_grant | s_park)))); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(s_attr)); // R6

  AST_SWITCH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_req != '0) && ($past(s_req) != '0) && (s_req != $past(s_req)))
      |-> $past(|(s_done & s_req))); // R4
endmodule

bind xbar_mport_gate xbg_checker #(.N_SLV(N_SLV), .ATTR_W(ATTR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .s_grant (s_grant),
  .s_park  (s_park),
  .s_done  (s_done),
  .s_req   (s_req),
  .s_attr  (s_attr)
);

// File: tb/xbar_mport_gate_test.sv
module xbar_mport_gate_test;
  localparam int N  = 4;
  localparam int TW = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mv = 1'b0;
  logic [TW-1:0] mt = '0;
  logic [AW-1:0] ma = '0;
  logic [N-1:0] g = '0, p = '0, d = '0;
  logic rdy, pen;
  logic [N-1:0] req;
  logic [AW-1:0] sa;

  int checks = 0;
  int errors = 0;

  // bench reference state
  bit busy = 0, cv = 0;
  logic [TW-1:0] oidx = '0, cidx = '0;
  logic [AW-1:0] cattr = '0;

  always #4 clk = ~clk;

  xbar_mport_gate #(.N_SLV(N), .ATTR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .m_valid(mv), .m_tgt(mt), .m_attr(ma),
    .m_ready(rdy), .s_grant(g), .s_park(p), .s_done(d),
    .s_req(req), .s_attr(sa), .pass_en(pen)
  );

  function automatic logic [TW-1:0] e_tgt();
    return cv ? cidx : mt;
  endfunction

  function automatic logic e_tv();
    return cv | mv;
  endfunction

  function automatic logic e_blk();
    return busy && (oidx != e_tgt());
  endfunction

  function automatic logic [N-1:0] e_req();
    if (e_tv() && !e_blk()) return N'(1) << e_tgt();
    if (busy) return N'(1) << oidx;
    return '0;
  endfunction

  function automatic logic e_rdy();
    logic [TW-1:0] t;
    t = e_tgt();
    return e_tv() && !e_blk() && (g[t] | p[t]);
  endfunction

  function automatic logic [AW-1:0] e_attr();
    return cv ? cattr : ma;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare this cycle, then advance the reference at the edge
  task automatic tick(string tag);
    logic r;
    #1;
    r = e_rdy();
    chk(tag, "s_req", 32'(req), 32'(e_req()));
    chk(tag, "m_ready", 32'(rdy), 32'(r));
    chk(tag, "pass_en", 32'(pen), 32'(r));
    if (e_tv()) chk(tag, "s_attr", 32'(sa), 32'(e_attr()));
    @(posedge clk);
    if (r) begin
      busy = 1; oidx = e_tgt(); cv = 0;
    end else begin
      if (mv && !cv) begin cv = 1; cidx = mt; cattr = ma; end
      if (busy && d[oidx]) busy = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit newacc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tick("R1");
    // R1 explicit reset values
    chk("R1", "reset s_req", 32'(req), 0);

    // R2: parked slave, zero-wait
    mv = 1; mt = 2; ma = 8'h5a; p = 4'b0100;
    tick("R2");
    // R7: outstanding holds request until completion, then drops
    mv = 0; p = 0;
    tick("R7");
    chk("R7", "held req", 32'(req), 32'h4);
    d = 4'b0100;
    tick("R7");
    d = 0;
    tick("R7");
    chk("R7", "dropped req", 32'(req), 0);

    // R3/R6: stall, then master changes its lines while stalled
    mv = 1; mt = 1; ma = 8'h11;
    tick("R3");
    tick("R3");
    mt = 3; ma = 8'hee;
    tick("R6");
    chk("R6", "captured attr", 32'(sa), 32'h11);
    chk("R6", "captured target", 32'(req), 32'h2);
    g = 4'b0010;
    tick("R3");
    mv = 0; g = 0;

    // R4: outstanding on slave 1, new access to slave 0 already granted
    mv = 1; mt = 0; ma = 8'h33; g = 4'b0001;
    tick("R4");
    chk("R4", "blocked ready", 32'(rdy), 0);
    d = 4'b1000;
    tick("R9");
    chk("R9", "other done ignored", 32'(req), 32'h2);
    d = 4'b0010;
    tick("R4");
    d = 0;
    tick("R4");
    chk("R4", "ready after done", 32'(rdy), 1);

    // R8: same slave again while outstanding
    mv = 1; mt = 0; ma = 8'h44;
    tick("R8");
    chk("R8", "same-slave pass", 32'(rdy), 1);
    mv = 0; g = 0;
    tick("R8");

    // random phase
    newacc = 1;
    for (int i = 0; i < 4000; i++) begin
      if (newacc) begin
        mv = ($urandom_range(0, 3) != 0);
        mt = TW'($urandom_range(0, N - 1));
        ma = AW'($urandom);
      end
      g = '0; p = '0; d = '0;
      for (int k = 0; k < N; k++) begin
        g[k] = ($urandom_range(0, 9) < 3);
        p[k] = ($urandom_range(0, 9) < 2);
        d[k] = ($urandom_range(0, 3) == 0);
      end
      #1;
      newacc = !mv || e_rdy();
      tick((i % 2 == 0) ? "R5" : "R4");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule